// File: doc/BRIEF.md
# Zero-Overhead Nested Loop Controller

This block generates the instruction fetch address for hardware loops, so that a loop body repeats without any branch instruction being fetched or executed. It holds a table of loop levels. Each level is described by the address of its first body instruction, the address of its last body instruction, an iteration count and the index of the level that encloses it. The fetch address normally advances by one per enabled cycle. When it meets the last address of the current level with iterations left, the next address is that level's first address. When the last iteration ends, fetch falls through past the loop and control returns to the enclosing level.

A level is entered when the fetch address equals its first address while its enclosing level is the current one; entry always reloads the level's count, so an inner loop runs its full count again on each pass of the outer loop. Two runtime requests change the flow. An early exit abandons the current level at once and continues after its last address. A jump moves control directly to the first address of any programmed level. Hazard checking between body instructions is left to software; the block only steers fetch.

Top module: `zol_ctrl`

## Requirements
- R1: After reset the fetch address is `RESET_PC` (0) and the current level reads the outer value `NL` (6), meaning no loop is active.
- R2: A configuration write (`cfg_we` with `fetch_en` low) stores first address, last address, count and enclosing level for level `cfg_sel`; a level with enclosing value `NL` is outermost. The level becomes current in the cycle after the fetch address equals its first address while its enclosing level is current.
- R3: When the fetch address equals the current level's last address and its remaining count is above one, the next fetch address is the level's first address and the count drops by one.
- R4: When the remaining count is one or zero at the last address, the next fetch address is last address plus one, the enclosing level becomes current, and the count is reloaded for the next entry.
- R5: With three nested levels (first/last addresses 2/10, 4/7, 5/5) and counts c0, c1, c2 (zero treated as one), the fetch address first reaches 11 after exactly 2 + c0·(5 + c1·(3 + c2)) enabled cycles from reset.
- R6: An early exit with a level current sets the next fetch address to that level's last address plus one and makes its enclosing level current.
- R7: A jump to a programmed level sets the next fetch address to that level's first address, makes it current and reloads its count.
- R8: In one cycle an early exit takes priority over a jump, and both take priority over loop-back and fall-through.
- R9: While `fetch_en` is low the fetch address and current level hold, whatever the exit and jump inputs do.
- R10: An early exit while no level is current has no effect; the fetch address advances by one.
- R11: Six levels can be nested, each loop repeating inside its enclosing one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | Advance fetch this cycle |
| cfg_we | input | 1 | Write a level descriptor |
| cfg_sel | input | LW (3) | Level index to write |
| cfg_start | input | AW (16) | First body address |
| cfg_end | input | AW (16) | Last body address |
| cfg_count | input | CW (8) | Iteration count |
| cfg_parent | input | LW (3) | Enclosing level, `NL` for outermost |
| exit_req | input | 1 | Leave the current level now |
| jump_req | input | 1 | Transfer control to `jump_sel` |
| jump_sel | input | LW (3) | Target level of a jump |
| fetch_pc | output | AW (16) | Current fetch address |
| cur_level | output | LW (3) | Current level, `NL` when none |

## Verification
Fetch address and current level are registered, so every effect of an enabled cycle (loop-back, fall-through, entry, exit, jump) appears exactly one clock later, and a configuration write is visible to the next enabled cycle. The bench drives inputs on the falling edge, steps its own model of the expected address and level with those inputs, and compares both outputs on the following falling edge, one full register stage after the decision. The cycle-count formula of R5 is counted in the same enabled cycles, from the first falling edge after reset.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [2:0] {
    ACT_STEP = 3'd0,
    ACT_LOOP = 3'd1,
    ACT_DONE = 3'd2,
    ACT_EXIT = 3'd3,
    ACT_JUMP = 3'd4
  } zol_act_e;
endpackage

// File: rtl/zol_desc_bank.sv
module zol_desc_bank #(
  parameter int NL = 6,
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic [CW-1:0] cfg_count,
  input  logic [LW-1:0] cfg_parent,
  input  logic          cnt_we,
  input  logic [LW-1:0] cnt_sel,
  input  logic [CW-1:0] cnt_wdata,
  output logic [AW-1:0] start_q  [NL],
  output logic [AW-1:0] end_q    [NL],
  output logic [CW-1:0] init_q   [NL],
  output logic [LW-1:0] parent_q [NL],
  output logic [CW-1:0] cnt_q    [NL],
  output logic [NL-1:0] valid_q
);
  for (genvar k = 0; k < NL; k++) begin : g_lvl
    logic cfg_hit;
    logic cnt_hit;
    logic [CW-1:0] cnt_d;

    assign cfg_hit = cfg_we && (cfg_sel == LW'(k));
    assign cnt_hit = cnt_we && (cnt_sel == LW'(k));

    always_comb begin
      cnt_d = cnt_q[k];
      if (cfg_hit)      cnt_d = cfg_count;
      else if (cnt_hit) cnt_d = cnt_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[k]  <= '0;
        end_q[k]    <= '0;
        init_q[k]   <= '0;
        parent_q[k] <= '0;
        valid_q[k]  <= 1'b0;
      end else if (cfg_hit) begin
        start_q[k]  <= cfg_start;
        end_q[k]    <= cfg_end;
        init_q[k]   <= cfg_count;
        parent_q[k] <= cfg_parent;
        valid_q[k]  <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q[k] <= '0;
      else if (cfg_hit || cnt_hit) cnt_q[k] <= cnt_d;
    end
  end
endmodule

// File: rtl/zol_entry_pick.sv
module zol_entry_pick #(
  parameter int NL = 6,
  parameter int AW = 16,
  parameter int LW = 3
) (
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] act,
  input  logic [AW-1:0] start_q  [NL],
  input  logic [LW-1:0] parent_q [NL],
  input  logic [NL-1:0] valid_q,
  output logic          hit,
  output logic [LW-1:0] hit_lvl
);
  logic [NL-1:0] match;

  for (genvar k = 0; k < NL; k++) begin : g_match
    assign match[k] = valid_q[k] && (parent_q[k] == act) &&
                      (start_q[k] == pc) && (act != LW'(k));
  end

  always_comb begin
    hit_lvl = '0;
    for (int k = NL - 1; k >= 0; k--) begin
      if (match[k]) hit_lvl = LW'(k);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/zol_seq.sv
module zol_seq
  import zol_pkg::*;
#(
  parameter int          NL       = 6,
  parameter int          AW       = 16,
  parameter int          CW       = 8,
  parameter int          LW       = 3,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          exit_req,
  input  logic          jump_req,
  input  logic [LW-1:0] jump_sel,
  input  logic          hit,
  input  logic [LW-1:0] hit_lvl,
  input  logic [AW-1:0] start_q  [NL],
  input  logic [AW-1:0] end_q    [NL],
  input  logic [CW-1:0] init_q   [NL],
  input  logic [LW-1:0] parent_q [NL],
  input  logic [CW-1:0] cnt_q    [NL],
  input  logic [NL-1:0] valid_q,
  output logic [AW-1:0] pc_q,
  output logic [LW-1:0] act_q,
  output logic [LW-1:0] eff_lvl,
  output logic [CW-1:0] eff_cnt,
  output logic          cnt_we,
  output logic [LW-1:0] cnt_sel,
  output logic [CW-1:0] cnt_wdata,
  output zol_act_e      kind
);
  localparam logic [LW-1:0] ROOT = LW'(NL);

  logic [AW-1:0] pc_d;
  logic [LW-1:0] act_d;
  logic [LW-1:0] eix;
  logic [LW-1:0] jix;
  logic          eff_live;
  logic          jump_ok;
  logic          upd_we;

  always_comb begin
    eff_lvl  = hit ? hit_lvl : act_q;
    eff_live = (eff_lvl != ROOT);
    eix      = eff_live ? eff_lvl : '0;
    jump_ok  = (jump_sel < ROOT) && valid_q[jump_sel < ROOT ? jump_sel : '0];
    jix      = jump_ok ? jump_sel : '0;
    eff_cnt  = hit ? init_q[eix] : cnt_q[eix];

    kind      = ACT_STEP;
    pc_d      = pc_q + AW'(1);
    act_d     = eff_lvl;
    upd_we    = hit;
    cnt_sel   = eix;
    cnt_wdata = init_q[eix];

    if (exit_req && eff_live) begin
      kind   = ACT_EXIT;
      pc_d   = end_q[eix] + AW'(1);
      act_d  = parent_q[eix];
      upd_we = 1'b1;
    end else if (jump_req && jump_ok) begin
      kind      = ACT_JUMP;
      pc_d      = start_q[jix];
      act_d     = jump_sel;
      upd_we    = 1'b1;
      cnt_sel   = jix;
      cnt_wdata = init_q[jix];
    end else if (eff_live && (pc_q == end_q[eix])) begin
      upd_we = 1'b1;
      if (eff_cnt > CW'(1)) begin
        kind      = ACT_LOOP;
        pc_d      = start_q[eix];
        cnt_wdata = eff_cnt - CW'(1);
      end else begin
        kind  = ACT_DONE;
        pc_d  = end_q[eix] + AW'(1);
        act_d = parent_q[eix];
      end
    end
  end

  assign cnt_we = adv && upd_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      act_q <= ROOT;
    end else if (adv) begin
      pc_q  <= pc_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int            NL       = 6,
  parameter int            AW       = 16,
  parameter int            CW       = 8,
  parameter logic [AW-1:0] RESET_PC = '0,
  localparam int           LW       = $clog2(NL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_en,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic [CW-1:0] cfg_count,
  input  logic [LW-1:0] cfg_parent,
  input  logic          exit_req,
  input  logic          jump_req,
  input  logic [LW-1:0] jump_sel,
  output logic [AW-1:0] fetch_pc,
  output logic [LW-1:0] cur_level
);
  localparam logic [LW-1:0] ROOT = LW'(NL);

  logic [AW-1:0] start_q  [NL];
  logic [AW-1:0] end_q    [NL];
  logic [CW-1:0] init_q   [NL];
  logic [LW-1:0] parent_q [NL];
  logic [CW-1:0] cnt_q    [NL];
  logic [NL-1:0] valid_q;

  logic          hit;
  logic [LW-1:0] hit_lvl;
  logic [LW-1:0] eff_lvl;
  logic [CW-1:0] eff_cnt;
  logic          cnt_we;
  logic [LW-1:0] cnt_sel;
  logic [CW-1:0] cnt_wdata;
  zol_act_e      kind;
  logic          cfg_ok;

  logic [LW-1:0] eff_ix;
  logic [AW-1:0] eff_start;
  logic [AW-1:0] eff_end;
  logic [LW-1:0] eff_par;

  assign cfg_ok = cfg_we && !fetch_en && (cfg_sel < ROOT);

  zol_desc_bank #(.NL(NL), .AW(AW), .CW(CW), .LW(LW)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_ok),
    .cfg_sel   (cfg_sel),
    .cfg_start (cfg_start),
    .cfg_end   (cfg_end),
    .cfg_count (cfg_count),
    .cfg_parent(cfg_parent),
    .cnt_we    (cnt_we),
    .cnt_sel   (cnt_sel),
    .cnt_wdata (cnt_wdata),
    .start_q   (start_q),
    .end_q     (end_q),
    .init_q    (init_q),
    .parent_q  (parent_q),
    .cnt_q     (cnt_q),
    .valid_q   (valid_q)
  );

  zol_entry_pick #(.NL(NL), .AW(AW), .LW(LW)) pick_i (
    .pc      (fetch_pc),
    .act     (cur_level),
    .start_q (start_q),
    .parent_q(parent_q),
    .valid_q (valid_q),
    .hit     (hit),
    .hit_lvl (hit_lvl)
  );

  zol_seq #(.NL(NL), .AW(AW), .CW(CW), .LW(LW), .RESET_PC(RESET_PC)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (fetch_en),
    .exit_req (exit_req),
    .jump_req (jump_req),
    .jump_sel (jump_sel),
    .hit      (hit),
    .hit_lvl  (hit_lvl),
    .start_q  (start_q),
    .end_q    (end_q),
    .init_q   (init_q),
    .parent_q (parent_q),
    .cnt_q    (cnt_q),
    .valid_q  (valid_q),
    .pc_q     (fetch_pc),
    .act_q    (cur_level),
    .eff_lvl  (eff_lvl),
    .eff_cnt  (eff_cnt),
    .cnt_we   (cnt_we),
    .cnt_sel  (cnt_sel),
    .cnt_wdata(cnt_wdata),
    .kind     (kind)
  );

  // Descriptor view of the level acting this cycle, observed by the checker.
  assign eff_ix    = (eff_lvl == ROOT) ? '0 : eff_lvl;
  assign eff_start = start_q[eff_ix];
  assign eff_end   = end_q[eff_ix];
  assign eff_par   = parent_q[eff_ix];
endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
  parameter int NL = 6,
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_en,
  input logic          exit_req,
  input logic          jump_req,
  input logic [AW-1:0] fetch_pc,
  input logic [LW-1:0] cur_level,
  input logic [LW-1:0] eff_lvl,
  input logic [CW-1:0] eff_cnt,
  input logic [AW-1:0] eff_start,
  input logic [AW-1:0] eff_end,
  input logic [LW-1:0] eff_par
);
  localparam logic [LW-1:0] ROOT = LW'(NL);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> ($stable(fetch_pc) && $stable(cur_level)));

  a_r3_loop_back: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !exit_req && !jump_req && (eff_lvl != ROOT) &&
     (fetch_pc == eff_end) && (eff_cnt > CW'(1)))
    |=> ((fetch_pc == $past(eff_start)) && (cur_level == $past(eff_lvl))));

  a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !exit_req && !jump_req && (eff_lvl != ROOT) &&
     (fetch_pc == eff_end) && (eff_cnt <= CW'(1)))
    |=> ((fetch_pc == AW'($past(eff_end) + AW'(1))) && (cur_level == $past(eff_par))));

  a_r6_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && exit_req && (eff_lvl != ROOT))
    |=> ((fetch_pc == AW'($past(eff_end) + AW'(1))) && (cur_level == $past(eff_par))));

  a_r2_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level <= ROOT);
endmodule

bind zol_ctrl zol_ctrl_chk #(.NL(NL), .AW(AW), .CW(CW), .LW(LW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .fetch_en (fetch_en),
  .exit_req (exit_req),
  .jump_req (jump_req),
  .fetch_pc (fetch_pc),
  .cur_level(cur_level),
  .eff_lvl  (eff_lvl),
  .eff_cnt  (eff_cnt),
  .eff_start(eff_start),
  .eff_end  (eff_end),
  .eff_par  (eff_par)
);

// File: tb/zol_ctrl_tb.sv
module zol_ctrl_tb_top;
  localparam int NL = 6;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int LW = 3;

  logic          clk;
  logic          rst_n;
  logic          fetch_en;
  logic          cfg_we;
  logic [LW-1:0] cfg_sel;
  logic [AW-1:0] cfg_start;
  logic [AW-1:0] cfg_end;
  logic [CW-1:0] cfg_count;
  logic [LW-1:0] cfg_parent;
  logic          exit_req;
  logic          jump_req;
  logic [LW-1:0] jump_sel;
  logic [AW-1:0] fetch_pc;
  logic [LW-1:0] cur_level;

  int n_checks = 0;
  int n_errors = 0;

  // Reference state
  int m_start [NL];
  int m_end   [NL];
  int m_init  [NL];
  int m_par   [NL];
  int m_cnt   [NL];
  bit m_val   [NL];
  int m_pc;
  int m_act;

  zol_ctrl #(.NL(NL), .AW(AW), .CW(CW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_en  (fetch_en),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_start (cfg_start),
    .cfg_end   (cfg_end),
    .cfg_count (cfg_count),
    .cfg_parent(cfg_parent),
    .exit_req  (exit_req),
    .jump_req  (jump_req),
    .jump_sel  (jump_sel),
    .fetch_pc  (fetch_pc),
    .cur_level (cur_level)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 190000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fetch_en = 1'b0; cfg_we = 1'b0; exit_req = 1'b0; jump_req = 1'b0;
    jump_sel = '0; cfg_sel = '0; cfg_start = '0; cfg_end = '0;
    cfg_count = '0; cfg_parent = '0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NL; k++) m_val[k] = 1'b0;
    m_pc  = 0;
    m_act = NL;
    @(negedge clk);
  endtask

  task automatic cfg(input int lvl, input int s, input int e, input int c, input int p);
    cfg_we = 1'b1; cfg_sel = LW'(lvl); cfg_start = AW'(s); cfg_end = AW'(e);
    cfg_count = CW'(c); cfg_parent = LW'(p);
    @(negedge clk);
    cfg_we = 1'b0;
    m_start[lvl] = s; m_end[lvl] = e; m_init[lvl] = c; m_par[lvl] = p;
    m_cnt[lvl] = c; m_val[lvl] = 1'b1;
  endtask

  task automatic m_step(input bit a, input bit e, input bit j, input int js);
    int eff;
    int hit;
    if (!a) return;
    eff = m_act;
    hit = -1;
    for (int k = 0; k < NL; k++)
      if (hit < 0 && m_val[k] && m_par[k] == m_act && m_start[k] == m_pc && k != m_act)
        hit = k;
    if (hit >= 0) begin
      eff = hit;
      m_cnt[hit] = m_init[hit];
    end
    if (e && eff != NL) begin
      m_pc = (m_end[eff] + 1) & 16'hFFFF; m_act = m_par[eff]; m_cnt[eff] = m_init[eff];
    end else if (j && js < NL && m_val[js]) begin
      m_pc = m_start[js]; m_act = js; m_cnt[js] = m_init[js];
    end else if (eff != NL && m_pc == m_end[eff]) begin
      if (m_cnt[eff] > 1) begin
        m_cnt[eff]--; m_pc = m_start[eff]; m_act = eff;
      end else begin
        m_cnt[eff] = m_init[eff]; m_pc = (m_end[eff] + 1) & 16'hFFFF; m_act = m_par[eff];
      end
    end else begin
      m_pc = (m_pc + 1) & 16'hFFFF; m_act = eff;
    end
  endtask

  // One cycle: drive at falling edge, compare one falling edge later.
  task automatic step(input bit a, input bit e, input bit j, input int js, input string tag);
    fetch_en = a; exit_req = e; jump_req = j; jump_sel = LW'(js);
    m_step(a, e, j, js);
    @(negedge clk);
    fetch_en = 1'b0; exit_req = 1'b0; jump_req = 1'b0;
    check(fetch_pc == AW'(m_pc), {tag, " pc"}, int'(fetch_pc), m_pc);
    check(cur_level == LW'(m_act), {tag, " level"}, int'(cur_level), m_act);
  endtask

  task automatic cfg_three(input int c0, input int c1, input int c2);
    cfg(0, 2, 10, c0, NL);
    cfg(1, 4, 7, c1, 0);
    cfg(2, 5, 5, c2, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();

    // R1: reset state
    check(fetch_pc == 16'd0, "R1 reset pc", int'(fetch_pc), 0);
    check(cur_level == LW'(NL), "R1 reset level", int'(cur_level), NL);

    // R10: exit with no level current only advances
    cfg_three(2, 2, 2);
    step(1'b1, 1'b1, 1'b0, 0, "R10 root exit");
    check(fetch_pc == 16'd1, "R10 pc after root exit", int'(fetch_pc), 1);

    // R5 / R2 / R3 / R4: sweep of counts on three nested levels
    for (int c0 = 1; c0 <= 3; c0++)
      for (int c1 = 1; c1 <= 3; c1++)
        for (int c2 = 0; c2 <= 3; c2++) begin
          int n;
          int expn;
          int k2;
          do_reset();
          cfg_three(c0, c1, c2);
          n = 0;
          while (m_pc != 11 && n < 300) begin
            step(1'b1, 1'b0, 1'b0, 0, "R3 R4 R2 sweep trace");
            n++;
          end
          k2 = (c2 == 0) ? 1 : c2;
          expn = 2 + c0 * (5 + c1 * (3 + k2));
          check(n == expn, "R5 cycles to loop exit", n, expn);
          check(cur_level == LW'(NL), "R4 back to outer", int'(cur_level), NL);
        end

    // R8: exit and jump together at inner last address with count left
    do_reset();
    cfg_three(3, 3, 2);
    begin
      int guard = 0;
      while (!(m_pc == 7 && m_act == 1) && guard < 100) begin
        step(1'b1, 1'b0, 1'b0, 0, "R8 approach");
        guard++;
      end
    end
    step(1'b1, 1'b1, 1'b1, 2, "R8 exit over jump");
    check(fetch_pc == 16'd8, "R8 pc after exit", int'(fetch_pc), 8);
    check(cur_level == 3'd0, "R8 level after exit", int'(cur_level), 0);

    // R6: exit from outer level
    step(1'b1, 1'b1, 1'b0, 0, "R6 exit outer");
    check(fetch_pc == 16'd11, "R6 pc after exit", int'(fetch_pc), 11);

    // R7: jump into an inner level
    step(1'b1, 1'b0, 1'b1, 1, "R7 jump");
    check(fetch_pc == 16'd4 && cur_level == 3'd1, "R7 jump target", int'(fetch_pc), 4);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b0, 0, "R7 after jump");

    // R9: hold while disabled, even with requests
    begin
      logic [AW-1:0] hp;
      logic [LW-1:0] hl;
      hp = fetch_pc; hl = cur_level;
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 0, "R9 hold");
      check(fetch_pc == hp, "R9 pc held", int'(fetch_pc), int'(hp));
      check(cur_level == hl, "R9 level held", int'(cur_level), int'(hl));
    end

    // R11: six nested levels, plain trace
    do_reset();
    cfg(0, 1, 30, 2, NL);
    cfg(1, 2, 28, 2, 0);
    cfg(2, 3, 25, 2, 1);
    cfg(3, 4, 22, 2, 2);
    cfg(4, 5, 18, 2, 3);
    cfg(5, 6, 10, 2, 4);
    begin
      bit saw_deep = 1'b0;
      for (int i = 0; i < 900 && m_pc != 31; i++) begin
        step(1'b1, 1'b0, 1'b0, 0, "R11 six-deep trace");
        if (cur_level == 3'd5) saw_deep = 1'b1;
      end
      check(saw_deep, "R11 innermost reached", int'(saw_deep), 1);
      check(fetch_pc == 16'd31, "R11 all loops done", int'(fetch_pc), 31);
    end

    // R6 / R7 / R8: six-deep trace with periodic exits and jumps
    do_reset();
    cfg(0, 1, 30, 3, NL);
    cfg(1, 2, 28, 2, 0);
    cfg(2, 3, 25, 3, 1);
    cfg(3, 4, 22, 2, 2);
    cfg(4, 5, 18, 3, 3);
    cfg(5, 6, 10, 2, 4);
    for (int i = 1; i <= 600; i++) begin
      bit e = (i % 17 == 0);
      bit j = (i % 29 == 0) || (i % 85 == 0);
      step(1'b1, e, j, i % 7, "R6 R7 R8 mixed trace");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule